// File: doc/BRIEF.md
# Extended-Data-Out DRAM Controller with CAS-before-RAS Refresh

This block is a synchronous controller placed between a host request port and one 4M-word by 4-bit extended-data-out DRAM. The DRAM multiplexes its address bus: the upper twelve bits of a 22-bit word address select a row when the row strobe falls, and the lower ten bits select a column when a column strobe falls. There are four column strobes, one per data bit, and each is lowered only when the matching bit of the request's lane mask is set. This lets single bits be written or read.

The host offers a request with a valid/ready handshake: a write flag, the word address, the lane mask and the write data. Once a row is activated it stays open, so later requests to the same row are served as page-mode column cycles without a new activation. A request to another row causes a precharge and a new activation. Writes use early write: the write strobe is low before any column strobe falls. Read data comes back with a one-cycle valid pulse, in the order the requests were accepted.

All DRAM timing limits are given in picoseconds and converted to clock counts by rounding up. A free-running interval timer requests one CAS-before-RAS refresh per interval. A pending refresh wins over host traffic and closes any open row first. An upper limit on the row-strobe low time closes the row even during a long run of page hits. After reset the controller waits for a power-up delay and then performs eight refreshes before it accepts any request.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is active and in the cycle after it, the row strobe, all four column strobes, the write strobe and the output enable are high (inactive), and `req_ready` and `rd_valid` are low.
- R2: `req_ready` stays low until at least the power-up delay has passed since reset and exactly eight CAS-before-RAS refreshes have been performed.
- R3: The row address `req_addr[21:10]` is on `dram_addr` when the row strobe falls. The column address `req_addr[9:0]` is on `dram_addr[9:0]` when a column strobe falls, with `dram_addr[11:10]` zero.
- R4: Column strobe `dram_cas_n[i]` falls for an access only if `req_mask[i]` is 1. A write leaves unmasked bits of the stored word unchanged. A read returns 0 on unmasked bits of `rd_data`.
- R5: Each accepted read produces exactly one single-cycle `rd_valid` pulse. The pulses come in acceptance order, and `rd_data` equals the last data written to that word on the masked bits.
- R6: For a write, `dram_we_n` is low in the cycle before the column strobe falls. `dram_oe_n` is never low while `dram_we_n` is low.
- R7: Consecutive accesses to the same row, with no refresh in between, cause no new row activation.
- R8: An access to a row other than the open one causes a precharge and a new activation. The row strobe is always high for at least the precharge count before it falls.
- R9: Refresh lowers all four column strobes, with the write strobe high, at least one cycle before the row strobe falls. Refreshes follow each other at most one interval plus one access sequence apart, and a due refresh closes an open row and is served before further host requests.
- R10: The row strobe falls at least the RAS-to-CAS count (ceil of RAS access minus CAS access time) before a column strobe falls. Each access keeps its column strobes low for at least the CAS count.
- R11: The row strobe never stays low for more than the maximum RAS-low count of cycles, even under a continuous stream of page hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request offered |
| req_ready | output | 1 | Controller accepts the request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address: [21:10] row, [9:0] column |
| req_mask | input | 4 | Per-bit lane enable |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 4 | Read data, unmasked bits zero |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 4 | Per-bit column strobes, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_dq_out | output | 4 | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Enable for the data drivers |
| dram_dq_in | input | 4 | Data returned by the DRAM |

## Verification
The assertions assume the host keeps `req_valid` and the request fields stable until `req_ready` is seen. They also assume the DRAM drives `dram_dq_in` from the column-strobe fall through the capture edge. The one-cycle `rd_valid` check assumes the parameters give at least a two-cycle page cycle, which holds because each access spends one cycle on column setup before its strobes fall. The bench drives requests at the falling clock edge and holds them until accepted. Its DRAM model drives read data only on bits whose column strobe and output enable are both low.

// File: rtl/edo_pkg.sv
package edo_pkg;

  localparam int ROW_W  = 12;
  localparam int COL_W  = 10;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int LANES  = 4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REF_CSR,
    S_REF_RAS,
    S_PRE,
    S_ACT,
    S_COL,
    S_CAS,
    S_OPEN
  } ctrl_state_e;

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  mask;
    logic [LANES-1:0]  wdata;
  } host_cmd_t;

  // round a time in picoseconds up to whole clocks, never below one
  function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
  parameter int C_PWR     = 20000,
  parameter int C_REFI    = 1560,
  parameter int INIT_REFS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ack,
  output logic ref_req,
  output logic init_done
);

  localparam int PWW = $clog2(C_PWR + 1);
  localparam int RW  = $clog2(C_REFI + 1);
  localparam int IW  = $clog2(INIT_REFS + 1);

  logic [PWW-1:0] pwr_q, pwr_d;
  logic [RW-1:0]  iv_q, iv_d;
  logic [IW-1:0]  init_q, init_d;
  logic           due_q, due_d;
  logic           pwr_done, tick;

  assign pwr_done = (pwr_q == PWW'(C_PWR));
  assign tick     = pwr_done && (iv_q == RW'(C_REFI - 1));

  always_comb begin
    pwr_d  = pwr_done ? pwr_q : pwr_q + 1'b1;
    iv_d   = !pwr_done ? iv_q : (tick ? '0 : iv_q + 1'b1);
    due_d  = tick ? 1'b1 : (ref_ack ? 1'b0 : due_q);
    init_d = (ref_ack && init_q != '0) ? init_q - 1'b1 : init_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q  <= '0;
      iv_q   <= '0;
      due_q  <= 1'b0;
      init_q <= IW'(INIT_REFS);
    end else begin
      pwr_q  <= pwr_d;
      iv_q   <= iv_d;
      due_q  <= due_d;
      init_q <= init_d;
    end
  end

  assign ref_req   = pwr_done && (due_q || init_q != '0);
  assign init_done = pwr_done && (init_q == '0);

  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ref_ack |-> $past(ref_req)); // R9

endmodule

// File: rtl/edo_ras_guard.sv
module edo_ras_guard #(
  parameter int C_RP     = 3,
  parameter int C_RASMAX = 1000,
  parameter int GUARD    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ras_n,
  output logic row_expire
);

  localparam int AW     = $clog2(C_RASMAX + 1);
  localparam int PW     = $clog2(C_RP + 1);
  localparam int THRESH = C_RASMAX - GUARD;

  logic [AW-1:0] age_q, age_d;
  logic [PW-1:0] pre_q, pre_d;

  always_comb begin
    if (ras_n)                       age_d = '0;
    else if (age_q != AW'(C_RASMAX)) age_d = age_q + 1'b1;
    else                             age_d = age_q;
    if (!ras_n)                      pre_d = '0;
    else if (pre_q != PW'(C_RP))     pre_d = pre_q + 1'b1;
    else                             pre_d = pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q <= '0;
      pre_q <= PW'(C_RP);
    end else begin
      age_q <= age_d;
      pre_q <= pre_d;
    end
  end

  assign row_expire = !ras_n && (age_q >= AW'(THRESH));

  AST_RAS_LOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (age_q < AW'(C_RASMAX))); // R11

  AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (pre_q >= PW'(C_RP))); // R8

endmodule

// File: rtl/edo_rd_capture.sv
module edo_rd_capture #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [LANES-1:0] lane_mask,
  input  logic [LANES-1:0] dq_in,
  output logic             rd_valid,
  output logic [LANES-1:0] rd_data
);

  logic             vld_q;
  logic [LANES-1:0] dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= cap_en;
      if (cap_en) dat_q <= dq_in & lane_mask;
    end
  end

  assign rd_valid = vld_q;
  assign rd_data  = dat_q;

  AST_RDV_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R5

endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter int CLK_PS      = 10000,
  parameter int T_RAC_PS    = 50000,
  parameter int T_CAC_PS    = 13000,
  parameter int T_PC_PS     = 20000,
  parameter int T_RP_PS     = 30000,
  parameter int T_RASMAX_PS = 10000000,
  parameter int T_REFI_PS   = 15600000,
  parameter int T_PWR_PS    = 200000000,
  parameter int INIT_REFS   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_mask,
  input  logic [LANES-1:0]  req_wdata,
  output logic              rd_valid,
  output logic [LANES-1:0]  rd_data,
  output logic              dram_ras_n,
  output logic [LANES-1:0]  dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [ROW_W-1:0]  dram_addr,
  output logic [LANES-1:0]  dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [LANES-1:0]  dram_dq_in
);

  localparam int C_RP     = ps_to_cyc(T_RP_PS, CLK_PS);
  localparam int C_RCD    = ps_to_cyc(T_RAC_PS - T_CAC_PS, CLK_PS);
  localparam int C_CAS    = max2(ps_to_cyc(T_CAC_PS, CLK_PS), ps_to_cyc(T_PC_PS, CLK_PS) - 1);
  localparam int C_RREF   = ps_to_cyc(T_RAC_PS, CLK_PS);
  localparam int C_RASMAX = ps_to_cyc(T_RASMAX_PS, CLK_PS);
  localparam int C_REFI   = ps_to_cyc(T_REFI_PS, CLK_PS);
  localparam int C_PWR    = ps_to_cyc(T_PWR_PS, CLK_PS);
  localparam int CNT_MAX  = max2(max2(C_RP, C_RCD), max2(C_CAS, C_RREF));
  localparam int CW       = $clog2(CNT_MAX + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  ctrl_state_e      state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic             pend_q, pend_d;
  host_cmd_t        cmd_q, req_cmd;
  logic             ref_req, init_done, ref_ack, row_expire;
  logic             accept, row_hit, cnt_zero, cap_en;

  assign req_cmd  = '{we: req_we, addr: req_addr, mask: req_mask, wdata: req_wdata};
  assign cnt_zero = (cnt_q == '0);
  assign row_hit  = (req_addr[ADDR_W-1:COL_W] == row_q);
  assign ref_ack  = (state_q == S_REF_CSR);

  assign req_ready = init_done && !ref_req &&
                     ((state_q == S_IDLE) || (state_q == S_OPEN && !row_expire));
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_zero ? cnt_q : cnt_q - 1'b1;
    row_d   = row_q;
    pend_d  = pend_q;
    unique case (state_q)
      S_IDLE: begin
        if (ref_req) begin
          state_d = S_REF_CSR;
        end else if (accept) begin
          state_d = S_ACT;
          cnt_d   = CW'(C_RCD - 1);
          row_d   = req_addr[ADDR_W-1:COL_W];
        end
      end
      S_REF_CSR: begin
        state_d = S_REF_RAS;
        cnt_d   = CW'(C_RREF - 1);
      end
      S_REF_RAS: begin
        if (cnt_zero) begin
          state_d = S_PRE;
          cnt_d   = CW'(C_RP - 1);
        end
      end
      S_PRE: begin
        if (cnt_zero) begin
          if (ref_req) begin
            state_d = S_REF_CSR;
          end else if (pend_q) begin
            state_d = S_ACT;
            cnt_d   = CW'(C_RCD - 1);
            row_d   = cmd_q.addr[ADDR_W-1:COL_W];
          end else begin
            state_d = S_IDLE;
          end
        end
      end
      S_ACT: begin
        if (cnt_zero) state_d = S_COL;
      end
      S_COL: begin
        state_d = S_CAS;
        cnt_d   = CW'(C_CAS - 1);
        pend_d  = 1'b0;
      end
      S_CAS: begin
        if (cnt_zero) state_d = S_OPEN;
      end
      S_OPEN: begin
        if (ref_req || row_expire) begin
          state_d = S_PRE;
          cnt_d   = CW'(C_RP - 1);
        end else if (accept) begin
          if (row_hit) begin
            state_d = S_COL;
          end else begin
            state_d = S_PRE;
            cnt_d   = CW'(C_RP - 1);
            pend_d  = 1'b1;
          end
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      row_q   <= '0;
      pend_q  <= 1'b0;
      cmd_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      row_q   <= row_d;
      pend_q  <= pend_d;
      if (accept) cmd_q <= req_cmd;
    end
  end

  // DRAM pin decode
  always_comb begin
    dram_ras_n  = !(state_q inside {S_ACT, S_COL, S_CAS, S_OPEN, S_REF_RAS});
    dram_cas_n  = '1;
    if (state_q == S_CAS) dram_cas_n = ~cmd_q.mask;
    else if (state_q inside {S_REF_CSR, S_REF_RAS}) dram_cas_n = '0;
    dram_addr   = (state_q inside {S_COL, S_CAS}) ?
                  ROW_W'(cmd_q.addr[COL_W-1:0]) : row_q;
    dram_we_n   = !(cmd_q.we && (state_q inside {S_COL, S_CAS}));
    dram_dq_oe  = cmd_q.we && (state_q inside {S_COL, S_CAS});
    dram_dq_out = cmd_q.wdata;
    dram_oe_n   = !(state_q == S_CAS && !cmd_q.we);
  end

  assign cap_en = (state_q == S_CAS) && cnt_zero && !cmd_q.we;

  edo_refresh_timer #(
    .C_PWR(C_PWR), .C_REFI(C_REFI), .INIT_REFS(INIT_REFS)
  ) u_timer (
    .clk(clk), .rst_n(rst_sync_q), .ref_ack(ref_ack),
    .ref_req(ref_req), .init_done(init_done)
  );

  edo_ras_guard #(
    .C_RP(C_RP), .C_RASMAX(C_RASMAX), .GUARD(C_CAS + 2)
  ) u_guard (
    .clk(clk), .rst_n(rst_sync_q), .ras_n(dram_ras_n), .row_expire(row_expire)
  );

  edo_rd_capture #(.LANES(LANES)) u_cap (
    .clk(clk), .rst_n(rst_sync_q), .cap_en(cap_en), .lane_mask(cmd_q.mask),
    .dq_in(dram_dq_in), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  AST_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ($rose(dram_cas_n != '1) && !dram_we_n && !dram_ras_n) |-> $past(!dram_we_n)); // R6

  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !dram_we_n |-> dram_oe_n); // R6

  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ($fell(dram_ras_n) && dram_cas_n != '1) |-> ($past(dram_cas_n) == '0 && dram_we_n)); // R9

endmodule

// File: tb/edo_dram_ctrl_tb.sv
module edo_dram_ctrl_tb;

  localparam int CLK_NS   = 10;
  localparam int TB_RP    = 3;
  localparam int TB_RCD   = 4;
  localparam int TB_CAS   = 2;
  localparam int TB_RASMX = 100;
  localparam int TB_REFI  = 300;
  localparam int TB_PWR   = 200;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_we;
  logic [21:0] req_addr;
  logic [3:0]  req_mask, req_wdata;
  logic        rd_valid;
  logic [3:0]  rd_data;
  logic        ras_n, we_n, oe_n, dq_oe;
  logic [3:0]  cas_n, dq_out, dq_in;
  logic [11:0] addr;

  edo_dram_ctrl #(
    .CLK_PS(CLK_NS * 1000), .T_RASMAX_PS(1000000),
    .T_REFI_PS(3000000), .T_PWR_PS(2000000)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_mask(req_mask), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
    .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(addr), .dram_dq_out(dq_out),
    .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
  );

  initial clk = 1'b0;
  always #(CLK_NS / 2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 1'b0;
  always @(posedge clk) cyc++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- DRAM model ----------------
  logic [3:0] mem [int unsigned];
  logic [3:0] rdword = '0;
  logic       p_ras = 1'b1, p_we = 1'b1, acc_on = 1'b0;
  logic [3:0] p_cas = 4'hF;
  logic [11:0] m_row = '0;
  logic [9:0]  m_col = '0;
  int ref_cnt = 0, act_cnt = 0, wr_seen = 0;
  int last_ref = -1, max_ref_gap = 0, ras_fall = 0, min_rcd = 1000;
  int cas_len = 0, min_cas = 1000, low_len = 0, max_low = 0;
  int high_len = 1000, min_pre = 1000;
  int ew_viol = 0, oe_viol = 0, cbr_viol = 0, col_viol = 0;

  always @(negedge clk) begin
    logic [3:0] w;
    int unsigned k;
    if (p_ras && !ras_n) begin
      if (high_len < min_pre) min_pre = high_len;
      if (cas_n != 4'hF) begin
        ref_cnt++;
        if (p_cas != 4'h0 || cas_n != 4'h0 || !we_n) cbr_viol++;
        if (last_ref >= 0 && cyc - last_ref > max_ref_gap) max_ref_gap = cyc - last_ref;
        last_ref = cyc;
      end else begin
        act_cnt++;
        m_row = addr;
        ras_fall = cyc;
      end
    end
    if (!ras_n && !p_ras && p_cas == 4'hF && cas_n != 4'hF) begin
      m_col = addr[9:0];
      if (addr[11:10] != 2'b00) col_viol++;
      if (cyc - ras_fall < min_rcd) min_rcd = cyc - ras_fall;
      k = {20'd0, m_row} * 1024 + {22'd0, m_col};
      w = mem.exists(k) ? mem[k] : 4'h0;
      if (!we_n) begin
        wr_seen++;
        if (p_we) ew_viol++;
        for (int i = 0; i < 4; i++) if (!cas_n[i] && dq_oe) w[i] = dq_out[i];
        mem[k] = w;
      end else begin
        rdword = w;
      end
      acc_on = 1'b1;
      cas_len = 0;
    end
    if (acc_on) begin
      if (cas_n != 4'hF) cas_len++;
      else begin
        acc_on = 1'b0;
        if (cas_len < min_cas) min_cas = cas_len;
      end
    end
    if (!oe_n && !we_n) oe_viol++;
    if (ras_n) begin high_len++; low_len = 0; end
    else begin
      high_len = 0;
      low_len++;
      if (low_len > max_low) max_low = low_len;
    end
    dq_in = rdword & ~cas_n & {4{~oe_n}};
    p_ras = ras_n; p_cas = cas_n; p_we = we_n;
  end

  // ---------------- scoreboard ----------------
  logic [3:0] exp_mem [int unsigned];
  logic [3:0] exp_q [$];

  task automatic issue(input logic we, input logic [21:0] a, input logic [3:0] m,
                       input logic [3:0] d);
    logic [3:0] cur;
    int unsigned k;
    k = {10'd0, a};
    cur = exp_mem.exists(k) ? exp_mem[k] : 4'h0;
    req_we = we; req_addr = a; req_mask = m; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    if (we) exp_mem[k] = (cur & ~m) | (d & m);
    else    exp_q.push_back(cur & m);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rd_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R5 unexpected rd_valid", 1, 0);
      else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        check(rd_data == e, "R5/R4 read data", int'(rd_data), int'(e));
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog expired", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int t0, a0, r0;
    rst_n = 1'b0; req_valid = 1'b0; req_we = 1'b0;
    req_addr = '0; req_mask = '0; req_wdata = '0; dq_in = '0;
    repeat (4) @(negedge clk);
    check(ras_n && cas_n == 4'hF && we_n && oe_n, "R1 strobes idle in reset",
          int'({ras_n, cas_n, we_n, oe_n}), 127);
    check(!req_ready && !rd_valid, "R1 ready/valid low in reset",
          int'({req_ready, rd_valid}), 0);
    rst_n = 1'b1;
    t0 = cyc;
    @(negedge clk);
    check(ras_n && cas_n == 4'hF && !req_ready, "R1 after release",
          int'({ras_n, cas_n, req_ready}), 62);

    while (!req_ready) @(negedge clk);
    check(ref_cnt == 8, "R2 refreshes before ready", ref_cnt, 8);
    check(cyc - t0 >= TB_PWR, "R2 power-up delay", cyc - t0, TB_PWR);

    // R3 address multiplexing
    issue(1'b1, 22'h2A53C7, 4'hF, 4'h9);
    repeat (12) @(negedge clk);
    check(m_row == 12'hA94, "R3 row on address bus", int'(m_row), 'hA94);
    check(m_col == 10'h3C7, "R3 column on address bus", int'(m_col), 'h3C7);

    // R5 data round trip, several rows and columns
    for (int i = 0; i < 8; i++)
      issue(1'b1, 22'((i * 37 + 5) << 10) | 22'(i * 91), 4'hF, 4'(i + 3));
    for (int i = 7; i >= 0; i--)
      issue(1'b0, 22'((i * 37 + 5) << 10) | 22'(i * 91), 4'hF, 4'h0);
    issue(1'b0, 22'h2A53C7, 4'hF, 4'h0);

    // R4 lane masking
    issue(1'b1, 22'h001234, 4'hF, 4'hA);
    issue(1'b1, 22'h001234, 4'b0101, 4'h5);
    issue(1'b0, 22'h001234, 4'hF, 4'h0);
    issue(1'b0, 22'h001234, 4'b0011, 4'h0);
    issue(1'b1, 22'h001234, 4'b1000, 4'h0);
    issue(1'b0, 22'h001234, 4'hF, 4'h0);

    // R7 page hits
    issue(1'b0, 22'h155000, 4'hF, 4'h0);
    a0 = act_cnt; r0 = ref_cnt;
    for (int i = 1; i < 5; i++) issue(1'b0, 22'h155000 | 22'(i), 4'hF, 4'h0);
    repeat (10) @(negedge clk);
    check(act_cnt - a0 <= ref_cnt - r0, "R7 no activation on page hits",
          act_cnt - a0, ref_cnt - r0);

    // R8 row misses
    a0 = act_cnt;
    for (int i = 0; i < 4; i++)
      issue(1'b0, (i % 2 == 0) ? 22'h3FF001 : 22'h000002, 4'hF, 4'h0);
    repeat (10) @(negedge clk);
    check(act_cnt - a0 >= 4, "R8 activation per row miss", act_cnt - a0, 4);

    // R11 long page-hit run
    for (int i = 0; i < 60; i++) issue(i % 3 == 0, 22'h0AB000 | 22'(i), 4'hF, 4'(i));
    for (int i = 0; i < 60; i++) issue(1'b0, 22'h0AB000 | 22'(i), 4'hF, 4'h0);
    repeat (700) @(negedge clk);

    check(max_low <= TB_RASMX, "R11 RAS low bound", max_low, TB_RASMX);
    check(min_pre >= TB_RP, "R8 precharge width", min_pre, TB_RP);
    check(min_rcd >= TB_RCD, "R10 RAS-to-CAS", min_rcd, TB_RCD);
    check(min_cas >= TB_CAS, "R10 CAS low width", min_cas, TB_CAS);
    check(col_viol == 0, "R3 column upper bits zero", col_viol, 0);
    check(ew_viol == 0 && wr_seen > 0, "R6 early write", ew_viol, 0);
    check(oe_viol == 0, "R6 OE off during write", oe_viol, 0);
    check(cbr_viol == 0, "R9 CAS before RAS order", cbr_viol, 0);
    check(max_ref_gap <= TB_REFI + 40, "R9 refresh spacing", max_ref_gap, TB_REFI + 40);
    check(ref_cnt >= 8 + (cyc - t0 - TB_PWR) / TB_REFI - 1, "R9 refresh count",
          ref_cnt, 8 + (cyc - t0 - TB_PWR) / TB_REFI - 1);
    check(exp_q.size() == 0, "R5 all reads returned", exp_q.size(), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule